// File: doc/BRIEF.md
# Single-Wire Bus Slot Responder

This block is the bit-level slave end of an open-drain single-wire bus. Each bit travels in its own time slot, and the master always opens the slot by pulling the line low. The block watches the already synchronized line level. On each falling edge it starts a slot counter. Upper logic says, through a mode input, whether the coming slot is one the master writes or one the slave answers.

In a write slot, the block samples the line a fixed number of clock cycles after the edge. It reports the sampled level as the received bit, together with a one-cycle valid strobe. In a read slot, the block captures the bit to send at the edge. After a setup delay it either keeps the line low for a fixed hold time, which sends a 0, or leaves the line alone, which sends a 1. A new slot is only accepted after the line has been high for a recovery time. An edge that comes too early, or that comes while a slot is still running, is discarded and flagged. Reset and presence handling, command decoding and storage are handled elsewhere.

Top module: `owSlotSlave`

## Requirements
- R1: While reset is asserted and right after it, rxValid, pullDown and protoErr are all 0.
- R2: A falling edge of wireIn that is accepted in a write slot (txMode=0) causes exactly one rxValid pulse, one cycle long. The pulse appears in the cycle after the clock edge that lies SAMPLE_CYC edges after the first edge to see the line low.
- R3: At that sample edge, a low line gives rxBit=0 and a high line gives rxBit=1.
- R4: In a read slot (txMode=1) with txBit=0 captured at the falling edge, pullDown rises after the edge SETUP_CYC edges past the detecting edge. It then stays high for exactly HOLD_CYC cycles. Changing txBit after the edge has no effect on the slot.
- R5: In a read slot with txBit=1 captured at the edge, pullDown stays 0 for the whole slot, so the line level at master sampling time is 1.
- R6: A read slot never produces rxValid. A write slot never asserts pullDown.
- R7: A falling edge that comes after fewer than RECOVER_CYC high cycles since the previous slot ended, or while a slot is still running, produces a one-cycle protoErr pulse in the following cycle. Such an edge starts no slot.
- R8: A falling edge that comes after at least RECOVER_CYC high cycles is accepted and raises no protoErr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| wireIn | input | 1 | Synchronized bus line level |
| txMode | input | 1 | 1: answer the next slot, 0: sample it |
| txBit | input | 1 | Bit to send in a read slot, captured at the falling edge |
| rxBit | output | 1 | Last bit sampled in a write slot |
| rxValid | output | 1 | One-cycle strobe marking a new rxBit |
| pullDown | output | 1 | Enable for the open-drain line driver |
| protoErr | output | 1 | One-cycle strobe for a falling edge that was rejected |

## Verification
Most internal faults show up within one slot as a timing shift. An off-by-one slot counter moves the rxValid pulse, or the edges of the pullDown window, by one cycle. A missed edge detection removes the pulse completely. A recovery counter that is wrong, or that never clears, shows up as a protoErr pulse in the wrong place, one cycle after the offending edge, followed by a missing or an extra rxValid SAMPLE_CYC cycles later. A mode or bit capture that is taken at the wrong time either drives the line during a write slot or releases it during a read-0 slot. The line level the master sees then differs in the same slot.

// File: rtl/owSlotPkg.sv
`timescale 1ns/1ps
package owSlotPkg;
  typedef struct packed {
    logic startSlot;
    logic sampleNow;
    logic driveOn;
    logic driveOff;
    logic badFall;
  } slotStrb_t;
endpackage

// File: rtl/owSlotCtrl.sv
`timescale 1ns/1ps
module owSlotCtrl
  import owSlotPkg::*;
#(
  parameter int SAMPLE_CYC  = 6000,
  parameter int SETUP_CYC   = 200,
  parameter int HOLD_CYC    = 6000,
  parameter int RECOVER_CYC = 1000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wireIn,
  input  logic      txMode,
  output slotStrb_t strb
);
  localparam int READ_END = SETUP_CYC + HOLD_CYC;
  localparam int LAST_CYC = (READ_END > SAMPLE_CYC) ? READ_END : SAMPLE_CYC;
  localparam int CW = $clog2(LAST_CYC + 1) + 1;
  localparam int RW = $clog2(RECOVER_CYC + 1) + 1;

  logic          wirePrev;
  logic          busy;
  logic          modeQ;
  logic [CW-1:0] slotCnt;
  logic [RW-1:0] highCnt;
  logic          fall;
  logic          recovered;
  logic          accept;
  logic          slotEnd;

  // edge seen this cycle; recovery counted in cycles of high line while idle
  assign fall      = wirePrev && !wireIn;
  assign recovered = (highCnt >= RW'(RECOVER_CYC));
  assign accept    = fall && !busy && recovered;
  assign slotEnd   = busy && (slotCnt == (modeQ ? CW'(READ_END) : CW'(SAMPLE_CYC)));

  always_comb begin
    strb.startSlot = accept;
    strb.badFall   = fall && !accept;
    strb.sampleNow = busy && !modeQ && (slotCnt == CW'(SAMPLE_CYC));
    strb.driveOn   = busy && modeQ && (slotCnt == CW'(SETUP_CYC));
    strb.driveOff  = busy && modeQ && (slotCnt == CW'(READ_END));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wirePrev <= 1'b0;
      busy     <= 1'b0;
      modeQ    <= 1'b0;
      slotCnt  <= '0;
    end else begin
      wirePrev <= wireIn;
      if (accept) begin
        busy    <= 1'b1;
        modeQ   <= txMode;
        slotCnt <= CW'(1);
      end else if (busy) begin
        slotCnt <= slotCnt + CW'(1);
        if (slotEnd) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highCnt <= '0;
    end else if (busy || !wireIn) begin
      highCnt <= '0;
    end else if (!recovered) begin
      highCnt <= highCnt + RW'(1);
    end
  end
endmodule

// File: rtl/owSlotData.sv
`timescale 1ns/1ps
module owSlotData
  import owSlotPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wireIn,
  input  logic      txBit,
  input  slotStrb_t strb,
  output logic      rxBit,
  output logic      rxValid,
  output logic      pullDown,
  output logic      protoErr
);
  logic bitQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitQ     <= 1'b1;
      rxBit    <= 1'b0;
      rxValid  <= 1'b0;
      pullDown <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      rxValid  <= strb.sampleNow;
      protoErr <= strb.badFall;
      if (strb.startSlot) bitQ <= txBit;
      if (strb.sampleNow) rxBit <= wireIn;
      if (strb.driveOff) pullDown <= 1'b0;
      else if (strb.driveOn && !bitQ) pullDown <= 1'b1;
    end
  end
endmodule

// File: rtl/owSlotSlave.sv
`timescale 1ns/1ps
module owSlotSlave
  import owSlotPkg::*;
#(
  parameter int SAMPLE_CYC  = 6000,
  parameter int SETUP_CYC   = 200,
  parameter int HOLD_CYC    = 6000,
  parameter int RECOVER_CYC = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic wireIn,
  input  logic txMode,
  input  logic txBit,
  output logic rxBit,
  output logic rxValid,
  output logic pullDown,
  output logic protoErr
);
  slotStrb_t strb;

  owSlotCtrl #(
    .SAMPLE_CYC (SAMPLE_CYC),
    .SETUP_CYC  (SETUP_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .RECOVER_CYC(RECOVER_CYC)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .wireIn(wireIn),
    .txMode(txMode),
    .strb  (strb)
  );

  owSlotData uData (
    .clk     (clk),
    .rstN    (rstN),
    .wireIn  (wireIn),
    .txBit   (txBit),
    .strb    (strb),
    .rxBit   (rxBit),
    .rxValid (rxValid),
    .pullDown(pullDown),
    .protoErr(protoErr)
  );
endmodule

// File: rtl/owSlotChecker.sv
`timescale 1ns/1ps
module owSlotChecker #(
  parameter int HOLD_CYC = 6000
) (
  input logic clk,
  input logic rstN,
  input logic wireIn,
  input logic rxValid,
  input logic pullDown,
  input logic protoErr
);
  localparam int HW = $clog2(HOLD_CYC + 1) + 1;
  logic [HW-1:0] pullRun;

  always_ff @(posedge clk) begin
    if (!rstN) pullRun <= '0;
    else if (!pullDown) pullRun <= '0;
    else if (pullRun <= HW'(HOLD_CYC)) pullRun <= pullRun + HW'(1);
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) rxValid |=> !rxValid); // R2
  AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rstN) pullDown |-> (pullRun < HW'(HOLD_CYC))); // R4
  AST_NO_PULL_ON_VALID: assert property (@(posedge clk) disable iff (!rstN) rxValid |-> !pullDown); // R6
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) protoErr |=> !protoErr); // R7
  AST_ERR_AFTER_LOW: assert property (@(posedge clk) disable iff (!rstN) protoErr |-> !$past(wireIn)); // R7
endmodule

bind owSlotSlave owSlotChecker #(.HOLD_CYC(HOLD_CYC)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .wireIn  (wireIn),
  .rxValid (rxValid),
  .pullDown(pullDown),
  .protoErr(protoErr)
);

// File: tb/sim_owSlotSlave.sv
`timescale 1ns/1ps
module sim_owSlotSlave;
  localparam int S  = 6;
  localparam int SU = 2;
  localparam int H  = 8;
  localparam int RC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterLow = 1'b0;
  logic txMode = 1'b0;
  logic txBit = 1'b1;
  logic wireIn;
  logic rxBit, rxValid, pullDown, protoErr;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  assign wireIn = ~(masterLow | pullDown);

  always #2.5 clk = ~clk;

  owSlotSlave #(
    .SAMPLE_CYC (S),
    .SETUP_CYC  (SU),
    .HOLD_CYC   (H),
    .RECOVER_CYC(RC)
  ) u0 (
    .clk(clk), .rstN(rstN), .wireIn(wireIn), .txMode(txMode), .txBit(txBit),
    .rxBit(rxBit), .rxValid(rxValid), .pullDown(pullDown), .protoErr(protoErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    masterLow = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // write slot: master low for lowLen cycles; sample at edge S after detection
  task automatic runWrite(input int lowLen);
    int expBit;
    expBit = (S < lowLen) ? 0 : 1;
    txMode = 1'b0;
    masterLow = 1'b1;
    for (int k = 1; k <= S + 3; k++) begin
      @(negedge clk);
      if (k == lowLen) masterLow = 1'b0;
      chk("R2 rxValid timing", rxValid, (k == S + 1) ? 1 : 0);
      chk("R6 no pull in write slot", pullDown, 0);
      if (k == S + 1) chk("R3 sampled bit", rxBit, expBit);
    end
    idle(RC + 3);
  endtask

  task automatic runRead(input logic b, input int lowLen);
    txMode = 1'b1;
    txBit = b;
    masterLow = 1'b1;
    for (int k = 1; k <= SU + H + 3; k++) begin
      @(negedge clk);
      if (k == lowLen) masterLow = 1'b0;
      if (k == 1) txBit = ~b;  // late change must be ignored (R4)
      chk(b ? "R5 pull stays off" : "R4 pull window", pullDown,
          (!b && k >= SU + 1 && k <= SU + H) ? 1 : 0);
      chk("R6 no rxValid in read slot", rxValid, 0);
      if (k == SU + 2) chk(b ? "R5 line level" : "R4 line level", wireIn, b);
    end
    idle(RC + 3);
  endtask

  // a write slot, then a new edge after g high cycles
  task automatic runGap(input int g);
    bit tooSoon;
    tooSoon = (g < RC);
    txMode = 1'b0;
    masterLow = 1'b1;
    for (int k = 1; k <= S + 1 + g; k++) begin
      @(negedge clk);
      if (k == 2) masterLow = 1'b0;
    end
    masterLow = 1'b1;
    for (int k = 1; k <= S + 2; k++) begin
      @(negedge clk);
      if (k == 2) masterLow = 1'b0;
      if (k == 1) chk(tooSoon ? "R7 early edge flagged" : "R8 recovered edge clean",
                      protoErr, tooSoon ? 1 : 0);
      if (k == S + 1) chk(tooSoon ? "R7 early edge ignored" : "R8 slot accepted",
                          rxValid, tooSoon ? 0 : 1);
    end
    idle(RC + 3);
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rxValid in reset", rxValid, 0);
    chk("R1 pullDown in reset", pullDown, 0);
    chk("R1 protoErr in reset", protoErr, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rxValid after reset", rxValid, 0);
    chk("R1 pullDown after reset", pullDown, 0);
    chk("R1 protoErr after reset", protoErr, 0);
    idle(RC + 3);

    for (int len = 1; len <= S + 3; len++) runWrite(len);
    for (int len = 1; len <= SU + 1; len++) begin
      runRead(1'b0, len);
      runRead(1'b1, len);
    end
    for (int g = 0; g <= RC + 1; g++) runGap(g);

    // edge while a write slot is still running (R7)
    txMode = 1'b0;
    masterLow = 1'b1;
    for (int k = 1; k <= S + 2; k++) begin
      @(negedge clk);
      if (k == 1 || k == 4) masterLow = 1'b0;
      if (k == 3) masterLow = 1'b1;
      if (k == 4) chk("R7 edge inside slot flagged", protoErr, 1);
      if (k == S + 1) begin
        chk("R7 running slot kept", rxValid, 1);
        chk("R3 sampled high", rxBit, 1);
      end
    end
    idle(RC + 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule